// File: doc/BRIEF.md
# Multiplexed DRAM Row/Column Address Sequencer

This block connects an 8-bit processor bus to a bank of one-bit-wide dynamic RAMs, where each bank of eight parts is wired in parallel as 16,384 bytes. Each byte needs 14 cell-address bits. The RAM parts have only 7 address pins, so the block splits every access into two halves on one 7-bit bus. Bits 0 to 6 go out first as the row and are strobed with RAS. After a set number of clocks the bus switches to bits 7 to 13, which are strobed as the column with CAS.

An access starts when three conditions hold at once: the memory request is low, the area enable from the system decoder is high, and the top two address bits fall inside the RAM window. The window begins at 0x4000 and by default covers two banks, up to 0xBFFF. RAS goes low at once and is shared by all banks. A counter of clocks since the request began drives the mux switch, and a later count drives CAS. Only the CAS line of the addressed bank is driven. The RAM write enable is low only while CAS is active and the write strobe is low. When the request is removed, every strobe returns to idle in that same cycle.

Top module: `dram_addr_seq`

## Requirements
- R1: While rst_n is low, ras_n is 1, every cas_n bit is 1 and we_n is 1.
- R2: An access is active only when mreq_n is 0, ram_en is 1 and addr[15:14] is 1 or 2 (addresses 0x4000 to 0xBFFF). Otherwise ras_n is 1 and all cas_n bits are 1 in the same cycle.
- R3: ras_n is 0 in every cycle in which an access is active, starting with the cycle in which it becomes active.
- R4: During the first RAS_TO_MUX (default 1) clocks of an active access, ma equals addr[6:0].
- R5: From clock RAS_TO_MUX of an access onward (clocks counted from 0 at the first active cycle), ma equals addr[13:7].
- R6: From clock RAS_TO_MUX+MUX_TO_CAS (default 2) onward, cas_n[b] is 0, where b = addr[15:14]-1. No other cas_n bit is 0 at any time.
- R7: we_n is 0 only when wr_n is 0 and a cas_n bit is 0. With wr_n high (a read), we_n stays 1 while CAS is active.
- R8: When the access stops being active, ras_n and all cas_n bits are 1 in that same cycle. The next access starts again from the row phase.
- R9: While the request is held, CAS stays low for any number of cycles and ma stays on the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| mreq_n | input | 1 | Memory request, active low |
| wr_n | input | 1 | Write strobe, active low |
| ram_en | input | 1 | Area enable from the system decoder, active high |
| ma | output | 7 | Multiplexed RAM address |
| ras_n | output | 1 | Row strobe, shared by all banks |
| cas_n | output | 2 | Per-bank column strobe, active low |
| we_n | output | 1 | RAM write enable, active low |

## Verification
The sequencer is driven with long reads and writes in each bank, which separate the row phase, the column phase and CAS timing, and which show that only the addressed bank's CAS line is driven. Requests cut off before CAS, or in the middle of CAS, show whether release happens in the same cycle and whether the next access restarts at the row. Requests outside the window, with ram_en low, and ones that begin right after a release show whether the decode and the cycle counter are independent of each other.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  function automatic logic tag_in_window(int tag, int base_tag, int n_banks);
    return (tag >= base_tag) && (tag < base_tag + n_banks);
  endfunction

  function automatic int bank_of(int tag, int base_tag);
    return tag - base_tag;
  endfunction

  function automatic logic phase_reached(int age, int threshold);
    return age >= threshold;
  endfunction

endpackage

// File: rtl/dram_win_decode.sv
module dram_win_decode
  import dram_seq_pkg::*;
#(
  parameter int TAG_W     = 2,
  parameter int BASE_TAG  = 1,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  addr_tag,
  input  logic              mreq_n,
  input  logic              ram_en,
  output logic              hit,
  output logic [BANK_W-1:0] bank
);
  logic in_win;

  always_comb begin
    in_win = tag_in_window(int'(addr_tag), BASE_TAG, NUM_BANKS);
    hit    = rst_n && !mreq_n && ram_en && in_win;
    bank   = BANK_W'(bank_of(int'(addr_tag), BASE_TAG));
  end
endmodule

// File: rtl/dram_phase_timer.sv
module dram_phase_timer
  import dram_seq_pkg::*;
#(
  parameter int RAS_TO_MUX = 1,
  parameter int MUX_TO_CAS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic col_phase,
  output logic cas_phase
);
  localparam int CAS_AT = RAS_TO_MUX + MUX_TO_CAS;
  localparam int AGE_W  = $clog2(CAS_AT + 1);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              age_q <= '0;
    else if (!hit)                           age_q <= '0;
    else if (int'(age_q) != CAS_AT)          age_q <= age_q + 1'b1;
  end

  always_comb begin
    col_phase = hit && phase_reached(int'(age_q), RAS_TO_MUX);
    cas_phase = hit && phase_reached(int'(age_q), CAS_AT);
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 7
) (
  input  logic [2*ROW_W-1:0] cell_addr,
  input  logic               col_phase,
  output logic [ROW_W-1:0]   ma
);
  always_comb
    ma = col_phase ? cell_addr[2*ROW_W-1:ROW_W] : cell_addr[ROW_W-1:0];
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq #(
  parameter int ADDR_W     = 16,
  parameter int ROW_W      = 7,
  parameter int BASE_TAG   = 1,
  parameter int NUM_BANKS  = 2,
  parameter int RAS_TO_MUX = 1,
  parameter int MUX_TO_CAS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 mreq_n,
  input  logic                 wr_n,
  input  logic                 ram_en,
  output logic [ROW_W-1:0]     ma,
  output logic                 ras_n,
  output logic [NUM_BANKS-1:0] cas_n,
  output logic                 we_n
);
  localparam int CELL_W = 2 * ROW_W;
  localparam int TAG_W  = ADDR_W - CELL_W;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              hit;
  logic [BANK_W-1:0] bank;
  logic              col_phase;
  logic              cas_phase;

  dram_win_decode #(
    .TAG_W(TAG_W), .BASE_TAG(BASE_TAG), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_dec (
    .rst_n(rst_n), .addr_tag(addr[ADDR_W-1:CELL_W]), .mreq_n(mreq_n),
    .ram_en(ram_en), .hit(hit), .bank(bank)
  );

  dram_phase_timer #(
    .RAS_TO_MUX(RAS_TO_MUX), .MUX_TO_CAS(MUX_TO_CAS)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .col_phase(col_phase), .cas_phase(cas_phase)
  );

  dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .cell_addr(addr[CELL_W-1:0]), .col_phase(col_phase), .ma(ma)
  );

  assign ras_n = ~hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cas
    assign cas_n[g] = ~(cas_phase && (int'(bank) == g));
  end

  assign we_n = ~(cas_phase && !wr_n);
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk #(
  parameter int ADDR_W    = 16,
  parameter int ROW_W     = 7,
  parameter int BASE_TAG  = 1,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 mreq_n,
  input logic                 wr_n,
  input logic                 ram_en,
  input logic [ROW_W-1:0]     ma,
  input logic                 ras_n,
  input logic [NUM_BANKS-1:0] cas_n,
  input logic                 we_n,
  input logic                 col_phase
);
  localparam int CELL_W = 2 * ROW_W;
  logic want;
  logic cas_any;
  always_comb begin
    want = !mreq_n && ram_en &&
           (int'(addr[ADDR_W-1:CELL_W]) >= BASE_TAG) &&
           (int'(addr[ADDR_W-1:CELL_W]) <  BASE_TAG + NUM_BANKS);
    cas_any = ~&cas_n;
  end

  always_comb if (!rst_n) a_r1_reset_idle: assert (ras_n && &cas_n && we_n);

  a_r2_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !want |-> (ras_n && &cas_n));
  a_r3_ras_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    want |-> !ras_n);
  a_r4_row_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !col_phase) |-> (ma == addr[ROW_W-1:0]));
  a_r5_col_bits: assert property (@(posedge clk) disable iff (!rst_n)
    col_phase |-> (ma == addr[CELL_W-1:ROW_W]));
  a_r6_one_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cas_n) <= 1);
  a_r6_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> (!ras_n && $past(!ras_n)));
  a_r7_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (cas_any && !wr_n));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreq_n) |-> (ras_n && &cas_n && we_n));
endmodule

bind dram_addr_seq dram_addr_seq_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .BASE_TAG(BASE_TAG), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .wr_n(wr_n),
  .ram_en(ram_en), .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .col_phase(col_phase)
);

// File: tb/test_dram_addr_seq.sv
module test_dram_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        mreq_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ram_en = 1'b0;
  logic [6:0]  ma;
  logic        ras_n;
  logic [1:0]  cas_n;
  logic        we_n;

  int checks = 0;
  int failures = 0;
  int age = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_addr_seq i_dram_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .wr_n(wr_n),
    .ram_en(ram_en), .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  function automatic bit ref_hit();
    return rst_n && !mreq_n && ram_en && addr >= 16'h4000 && addr < 16'hC000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 0;
    else if (!ref_hit()) age <= 0;
    else if (age < 2)    age <= age + 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit h = ref_hit();
    bit col = h && age >= 1;
    bit cas = h && age >= 2;
    int bank = (addr >> 14) - 1;
    int exp_cas = cas ? (~(1 << bank) & 3) : 3;
    int exp_ma = col ? ((addr >> 7) & 127) : (addr & 127);
    if (!rst_n) begin
      check("R1 ras_n", ras_n, 1);
      check("R1 cas_n", cas_n, 3);
      check("R1 we_n", we_n, 1);
    end else begin
      check(h ? "R3 ras_n" : "R2 ras_n", ras_n, !h);
      check(cas ? "R6 cas_n" : "R2/R8 cas_n", cas_n, exp_cas);
      check("R7 we_n", we_n, !(cas && !wr_n));
      if (h) check(col ? "R5 ma" : "R4 ma", ma, exp_ma);
    end
  endtask

  task automatic step(logic [15:0] a, logic m, logic w, logic en);
    @(negedge clk);
    addr = a; mreq_n = m; wr_n = w; ram_en = en;
    #1 compare_all();
  endtask

  task automatic access(logic [15:0] a, logic w, int hold);
    for (int i = 0; i < hold; i++) step(a, 1'b0, w, 1'b1);
    step(a, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: drive a would-be hit during reset
    step(16'h4123, 1'b0, 1'b0, 1'b1);
    step(16'h4123, 1'b0, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1; mreq_n = 1'b1;
    step(16'h0000, 1'b1, 1'b1, 1'b0);
    // R4 R5 R6 R9: long read in bank 0
    access(16'h5A3C, 1'b1, 6);
    // R6 R7: write in bank 1
    access(16'h9F81, 1'b0, 5);
    // R8: released before CAS, then again during CAS
    access(16'h7FFF, 1'b0, 2);
    access(16'h4001, 1'b0, 3);
    // R8: immediate restart after a one-cycle gap
    access(16'hBFFF, 1'b1, 4);
    access(16'h8080, 1'b0, 4);
    // R2: outside window and area disabled
    for (int i = 0; i < 4; i++) step(16'h1234, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(16'hC000, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(16'h6543, 1'b0, 1'b0, 1'b0);
    // R2: window entered mid-request restarts at row
    for (int i = 0; i < 4; i++) step(16'h6543, 1'b0, 1'b1, 1'b1);
    // sweep a spread of addresses
    for (int k = 0; k < 24; k++) access(16'h4000 + 16'(k * 16'h0535), k[0], 1 + (k % 5));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule